// File: doc/BRIEF.md
# AUX Request Command Packer

This block assembles one auxiliary-channel request in a local byte store and hands it to the wire engine. The host presents a 20-bit target address, a read or write direction, a native or I2C-over-AUX type, two optional I2C qualifiers, and a byte count. The block first screens the request. An empty request is acknowledged at once. An oversized request is refused. Neither of these touches the store.

A legal request is written into the store through an indexed data port. Four header bytes come first. For writes, the payload bytes follow, fetched from the host by index. Once the last byte is queued, the block pulses a start strobe together with its qualifiers. It then waits for the wire engine to report completion. For reads, the wire engine deposits the reply (status byte first, then data) into the same store. The block then rewinds the store pointer with a read command word, drops the status byte, and streams the data bytes out with their indices. It stops at the first byte whose index is out of sequence and reports how many bytes arrived.

Top module: `aux_cmd_packer`

## Requirements
- R1: After reset and while idle, `done`, `go`, `port_we`, `rd_valid` and `req_busy` are all low.
- R2: Header word k carries this byte: k=0 holds address bits 19:16 in bits 3:0, with bit 4 set for a read and bits 7:5 zero; k=1 is address bits 15:8; k=2 is address bits 7:0; k=3 is the byte count minus one.
- R3: A port word is 10 bits: bit 9 is the index-reset flag, bit 8 is the read direction, and bits 7:0 are data. Bit 9 is set on header word 0 and on no other packing word. Bit 8 is zero while packing.
- R4: For a write, the payload bytes follow the header one per cycle in index order, with `pld_idx` giving the index. For a read, only the four header words are queued. Words are issued in consecutive cycles starting the cycle after acceptance.
- R5: `go` is a one-cycle pulse in the cycle after the last queued word, and no word is queued during it. `go_i2c` is the inverse of native. `go_no_addr` and `go_no_stop` follow the request flags for I2C requests only and are zero for native requests.
- R6: A request is refused with status 2 when it is native and longer than 16 bytes, longer than 128 bytes, or a write longer than 124 bytes. `done` is reported in the cycle after acceptance, with a count of 0, and no word or `go` is issued.
- R7: A zero-length request completes in the cycle after acceptance with status 1 and a count of 0, and no word or `go` is issued.
- R8: After `link_done` on a read, the block issues one port word 0x300 (index reset plus read direction). The next cycle discards stored byte 0. From then on, each cycle presents stored byte i+1 on `rd_byte` with `rd_valid` and `rd_idx`=i.
- R9: Readback ends at the first byte whose stored index does not match, or after the requested count. `done` follows with status 0 and `done_count` equal to the bytes delivered, which is the smaller of the bytes returned and the bytes requested.
- R10: A `req_valid` while the block is not idle (including the completion cycle) raises `req_busy` in that cycle and leaves the transfer in progress unaffected.
- R11: For a write, `done` appears in the cycle after `link_done` with status 0 and a count equal to the request length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start request |
| req_read | input | 1 | 1 = read, 0 = write |
| req_native | input | 1 | 1 = native request, 0 = I2C-over-AUX |
| req_no_addr | input | 1 | I2C qualifier: skip address phase |
| req_no_stop | input | 1 | I2C qualifier: skip stop |
| req_addr | input | 20 | Target address |
| req_len | input | 8 | Byte count (0..255) |
| req_busy | output | 1 | Request refused because a transfer is active |
| pld_idx | output | 8 | Index of payload byte wanted |
| pld_data | input | 8 | Payload byte at `pld_idx` |
| port_we | output | 1 | Data-port word valid |
| port_word | output | 10 | {index reset, read dir, data} |
| go | output | 1 | Start strobe to wire engine |
| go_i2c | output | 1 | Request is I2C-over-AUX |
| go_no_addr | output | 1 | No-send-address qualifier |
| go_no_stop | output | 1 | No-send-stop qualifier |
| rx_we | input | 1 | Reply byte write |
| rx_first | input | 1 | Reply byte is the first (goes to slot 0) |
| rx_byte | input | 8 | Reply byte |
| link_done | input | 1 | Wire engine finished |
| rd_valid | output | 1 | Readback byte valid |
| rd_byte | output | 8 | Readback byte |
| rd_idx | output | 8 | Readback byte index |
| done | output | 1 | Request complete |
| done_status | output | 2 | 0 ok, 1 empty, 2 bad length |
| done_count | output | 8 | Bytes delivered |

## Verification
The completion of a running transfer and a fresh start request can land in the same cycle. The bench raises `req_valid` with a zero-length request in the cycle it signals `link_done` and holds it high. It expects `req_busy` both there and in the completion cycle, with the write's own count still correct. The held request must then be accepted one cycle later and answered as empty. An index mismatch and the last requested byte can also coincide. Replies that are exactly the requested length, shorter, and longer are judged against the delivered count computed in the bench.

// File: rtl/aux_pk.sv
package aux_pk;
  localparam int HDR_BYTES = 4;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_EMPTY  = 2'd1,
    ST_BADLEN = 2'd2
  } aux_status_e;

  typedef struct packed {
    logic       idx_rst;
    logic       rd_dir;
    logic [7:0] data;
  } port_word_t;

  // header byte k of a request
  function automatic logic [7:0] hdr_byte(input logic [19:0] addr, input logic rd,
                                          input logic [7:0] len, input logic [1:0] k);
    case (k)
      2'd0:    return {3'b000, rd, addr[19:16]};
      2'd1:    return addr[15:8];
      2'd2:    return addr[7:0];
      default: return len - 8'd1;
    endcase
  endfunction

  // screening of a request against the size limits
  function automatic aux_status_e verdict(input logic native, input logic rd, input logic [7:0] len,
                                          input int nmax, input int imax, input int pmax);
    if (len == 8'd0)                    return ST_EMPTY;
    if (native && int'(len) > nmax)     return ST_BADLEN;
    if (int'(len) > imax)               return ST_BADLEN;
    if (!rd && int'(len) > pmax)        return ST_BADLEN;
    return ST_OK;
  endfunction
endpackage

// File: rtl/aux_req_check.sv
module aux_req_check
  import aux_pk::*;
#(
  parameter int NATIVE_MAX = 16,
  parameter int I2C_MAX    = 128,
  parameter int PLD_MAX    = 124
) (
  input  logic        native,
  input  logic        rd,
  input  logic [7:0]  len,
  output aux_status_e status
);
  always_comb status = verdict(native, rd, len, NATIVE_MAX, I2C_MAX, PLD_MAX);
endmodule

// File: rtl/aux_byte_fifo.sv
module aux_byte_fifo
  import aux_pk::*;
#(
  parameter  int DEPTH = 144,
  localparam int PW    = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  port_word_t cmd_word,
  input  logic       rx_we,
  input  logic       rx_first,
  input  logic [7:0] rx_byte,
  input  logic       pop,
  output logic [7:0] pop_data,
  output logic [7:0] pop_index
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] ptr, fill, base, nxt_ptr, nxt_fill;
  logic          wr_en;
  logic [7:0]    wr_data;

  always_comb begin
    base     = ptr;
    nxt_ptr  = ptr;
    nxt_fill = fill;
    wr_en    = 1'b0;
    wr_data  = 8'd0;
    if (rx_we) begin
      base     = rx_first ? '0 : ptr;
      wr_en    = base < PW'(DEPTH);
      wr_data  = rx_byte;
      nxt_ptr  = wr_en ? base + 1'b1 : base;
      nxt_fill = nxt_ptr;
    end else if (cmd_we) begin
      base = cmd_word.idx_rst ? '0 : ptr;
      if (!cmd_word.rd_dir) begin
        wr_en    = base < PW'(DEPTH);
        wr_data  = cmd_word.data;
        nxt_ptr  = wr_en ? base + 1'b1 : base;
        nxt_fill = nxt_ptr;
      end else begin
        nxt_ptr = base;
      end
    end else if (pop && ptr < PW'(DEPTH)) begin
      nxt_ptr = ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr  <= '0;
      fill <= '0;
    end else begin
      ptr  <= nxt_ptr;
      fill <= nxt_fill;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[base] <= wr_data;
  end

  assign pop_data  = (ptr < PW'(DEPTH)) ? mem[ptr] : 8'd0;
  // slot 0 holds the reply status byte, so data index is slot minus one
  assign pop_index = (ptr < fill && ptr != '0) ? 8'(ptr - 1'b1) : 8'hFF;

  p_fill_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= PW'(DEPTH));
  p_ptr_rewind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_word.idx_rst && !rx_we) |=> (ptr <= PW'(1)));
endmodule

// File: rtl/aux_pack_fsm.sv
module aux_pack_fsm
  import aux_pk::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_read,
  input  logic        req_native,
  input  logic        req_no_addr,
  input  logic        req_no_stop,
  input  logic [19:0] req_addr,
  input  logic [7:0]  req_len,
  input  aux_status_e chk_status,
  output logic        req_busy,
  output logic [7:0]  pld_idx,
  input  logic [7:0]  pld_data,
  output logic        port_we,
  output port_word_t  port_word,
  output logic        go,
  output logic        go_i2c,
  output logic        go_no_addr,
  output logic        go_no_stop,
  input  logic        link_done,
  output logic        pop,
  input  logic [7:0]  pop_data,
  input  logic [7:0]  pop_index,
  output logic        rd_valid,
  output logic [7:0]  rd_byte,
  output logic [7:0]  rd_idx,
  output logic        done,
  output aux_status_e done_status,
  output logic [7:0]  done_count
);
  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_PLD, S_GO, S_WAIT, S_RBCMD, S_RBSKIP, S_RBREAD, S_DONE
  } st_e;

  st_e         st;
  logic [7:0]  cnt, len_q, count_q;
  logic [19:0] addr_q;
  logic        rd_q, nat_q, na_q, ns_q;
  aux_status_e status_q;
  logic        req_fire, idx_match;

  assign req_fire  = req_valid && st == S_IDLE;
  assign req_busy  = req_valid && st != S_IDLE;
  assign idx_match = pop_index == cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= 8'd0;
      len_q    <= 8'd0;
      count_q  <= 8'd0;
      addr_q   <= 20'd0;
      rd_q     <= 1'b0;
      nat_q    <= 1'b0;
      na_q     <= 1'b0;
      ns_q     <= 1'b0;
      status_q <= ST_OK;
    end else begin
      case (st)
        S_IDLE: if (req_fire) begin
          addr_q   <= req_addr;
          len_q    <= req_len;
          rd_q     <= req_read;
          nat_q    <= req_native;
          na_q     <= req_no_addr;
          ns_q     <= req_no_stop;
          cnt      <= 8'd0;
          count_q  <= 8'd0;
          status_q <= chk_status;
          st       <= (chk_status == ST_OK) ? S_HDR : S_DONE;
        end
        S_HDR: begin
          if (cnt == 8'(HDR_BYTES - 1)) begin
            cnt <= 8'd0;
            st  <= rd_q ? S_GO : S_PLD;
          end else cnt <= cnt + 8'd1;
        end
        S_PLD: begin
          if (cnt == len_q - 8'd1) begin
            cnt <= 8'd0;
            st  <= S_GO;
          end else cnt <= cnt + 8'd1;
        end
        S_GO: st <= S_WAIT;
        S_WAIT: if (link_done) begin
          if (rd_q) st <= S_RBCMD;
          else begin
            count_q <= len_q;
            st      <= S_DONE;
          end
        end
        S_RBCMD:  st <= S_RBSKIP;
        S_RBSKIP: begin
          cnt <= 8'd0;
          st  <= S_RBREAD;
        end
        S_RBREAD: begin
          if (!idx_match) begin
            count_q <= cnt;
            st      <= S_DONE;
          end else if (cnt == len_q - 8'd1) begin
            count_q <= len_q;
            st      <= S_DONE;
          end else cnt <= cnt + 8'd1;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    port_we   = 1'b0;
    port_word = '0;
    case (st)
      S_HDR: begin
        port_we   = 1'b1;
        port_word = '{idx_rst: cnt == 8'd0, rd_dir: 1'b0,
                      data: hdr_byte(addr_q, rd_q, len_q, cnt[1:0])};
      end
      S_PLD: begin
        port_we   = 1'b1;
        port_word = '{idx_rst: 1'b0, rd_dir: 1'b0, data: pld_data};
      end
      S_RBCMD: begin
        port_we   = 1'b1;
        port_word = '{idx_rst: 1'b1, rd_dir: 1'b1, data: 8'd0};
      end
      default: ;
    endcase
  end

  assign pld_idx     = (st == S_PLD) ? cnt : 8'd0;
  assign go          = st == S_GO;
  assign go_i2c      = go && !nat_q;
  assign go_no_addr  = go && !nat_q && na_q;
  assign go_no_stop  = go && !nat_q && ns_q;
  assign pop         = st == S_RBSKIP || st == S_RBREAD;
  assign rd_valid    = st == S_RBREAD && idx_match;
  assign rd_byte     = rd_valid ? pop_data : 8'd0;
  assign rd_idx      = rd_valid ? cnt : 8'd0;
  assign done        = st == S_DONE;
  assign done_status = done ? status_q : ST_OK;
  assign done_count  = done ? count_q : 8'd0;

  p_go_after_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> $past(port_we));
  p_go_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);
  p_err_no_queue_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_status != ST_OK) |-> $past(req_fire));
  p_refuse_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_busy |=> ($stable(len_q) && $stable(addr_q) && $stable(rd_q)));
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> done_count <= len_q);
  p_rd_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid)) |-> rd_idx == 8'($past(rd_idx) + 8'd1));
endmodule

// File: rtl/aux_cmd_packer.sv
module aux_cmd_packer
  import aux_pk::*;
#(
  parameter  int DEPTH      = 144,
  parameter  int CMD_LIMIT  = 128,
  parameter  int NATIVE_MAX = 16,
  parameter  int I2C_MAX    = 128,
  localparam int PLD_MAX    = CMD_LIMIT - HDR_BYTES
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_read,
  input  logic        req_native,
  input  logic        req_no_addr,
  input  logic        req_no_stop,
  input  logic [19:0] req_addr,
  input  logic [7:0]  req_len,
  output logic        req_busy,
  output logic [7:0]  pld_idx,
  input  logic [7:0]  pld_data,
  output logic        port_we,
  output logic [9:0]  port_word,
  output logic        go,
  output logic        go_i2c,
  output logic        go_no_addr,
  output logic        go_no_stop,
  input  logic        rx_we,
  input  logic        rx_first,
  input  logic [7:0]  rx_byte,
  input  logic        link_done,
  output logic        rd_valid,
  output logic [7:0]  rd_byte,
  output logic [7:0]  rd_idx,
  output logic        done,
  output logic [1:0]  done_status,
  output logic [7:0]  done_count
);
  aux_status_e chk_status, st_out;
  port_word_t  word;
  logic        pop;
  logic [7:0]  pop_data, pop_index;

  aux_req_check #(.NATIVE_MAX(NATIVE_MAX), .I2C_MAX(I2C_MAX), .PLD_MAX(PLD_MAX)) u_check (
    .native(req_native), .rd(req_read), .len(req_len), .status(chk_status)
  );

  aux_pack_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_read(req_read), .req_native(req_native),
    .req_no_addr(req_no_addr), .req_no_stop(req_no_stop),
    .req_addr(req_addr), .req_len(req_len), .chk_status(chk_status),
    .req_busy(req_busy), .pld_idx(pld_idx), .pld_data(pld_data),
    .port_we(port_we), .port_word(word),
    .go(go), .go_i2c(go_i2c), .go_no_addr(go_no_addr), .go_no_stop(go_no_stop),
    .link_done(link_done), .pop(pop), .pop_data(pop_data), .pop_index(pop_index),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .rd_idx(rd_idx),
    .done(done), .done_status(st_out), .done_count(done_count)
  );

  aux_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .cmd_we(port_we), .cmd_word(word),
    .rx_we(rx_we), .rx_first(rx_first), .rx_byte(rx_byte),
    .pop(pop), .pop_data(pop_data), .pop_index(pop_index)
  );

  assign port_word   = word;
  assign done_status = st_out;
endmodule

// File: tb/aux_cmd_packer_bench.sv
module aux_cmd_packer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_read = 0, req_native = 0, req_no_addr = 0, req_no_stop = 0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_len = '0;
  logic req_busy, port_we, go, go_i2c, go_no_addr, go_no_stop, rd_valid, done;
  logic [7:0] pld_idx, pld_data, rd_byte, rd_idx, done_count;
  logic [9:0] port_word;
  logic [1:0] done_status;
  logic rx_we = 0, rx_first = 0, link_done = 0;
  logic [7:0] rx_byte = '0;
  logic [7:0] pat_base = 8'h11, rep_base = 8'h40;
  int total = 0, bad = 0, cyc = 0;

  always #10 clk = ~clk;

  assign pld_data = 8'(pat_base + 8'(3 * pld_idx));

  aux_cmd_packer u_aux_cmd_packer (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  function automatic int exp_verdict(input bit rd, input bit nat, input int len);
    if (len == 0) return 1;
    if (len > (nat ? 16 : 128)) return 2;
    if (!rd && len > 124) return 2;
    return 0;
  endfunction

  function automatic logic [9:0] exp_word(input int k, input bit rd, input logic [19:0] a, input int len);
    logic [7:0] b;
    if (k == 0)      b = (rd ? 8'h10 : 8'h00) | 8'((a >> 16) & 20'hF);
    else if (k == 1) b = 8'((a >> 8) & 20'hFF);
    else if (k == 2) b = 8'(a & 20'hFF);
    else if (k == 3) b = 8'(len - 1);
    else             b = 8'(pat_base + 8'(3 * (k - 4)));
    return {(k == 0), 1'b0, b};
  endfunction

  function automatic logic [7:0] rep(input int i);
    return 8'(rep_base + 8'(5 * i) + 8'(i >> 3));
  endfunction

  task automatic run_txn(input bit rd, input bit nat, input bit na, input bit ns,
                         input logic [19:0] a, input int len, input int nret,
                         input bit poke, input bit collide);
    int v, k, n, got, guard;
    pat_base  = 8'($urandom);
    rep_base  = 8'($urandom);
    req_read = rd; req_native = nat; req_no_addr = na; req_no_stop = ns;
    req_addr = a; req_len = 8'(len); req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    v = exp_verdict(rd, nat, len);
    if (v != 0) begin
      chk(done == 1, (v == 1) ? "R7 done" : "R6 done", done, 1);
      chk(done_status == 2'(v), (v == 1) ? "R7 status" : "R6 status", done_status, v);
      chk(done_count == 0 && !port_we && !go, (v == 1) ? "R7 quiet" : "R6 quiet", done_count, 0);
      @(negedge clk);
      chk(!done && !port_we && !go, "R6 idle after", done, 0);
      return;
    end
    k = 0; guard = 0;
    while (!go && guard < 200) begin
      chk(port_we == 1, "R4 word stream", port_we, 1);
      chk(port_word == exp_word(k, rd, a, len), (k < 4) ? "R2 R3 header" : "R4 payload",
          port_word, exp_word(k, rd, a, len));
      if (k >= 4) chk(pld_idx == 8'(k - 4), "R4 pld_idx", pld_idx, k - 4);
      k++; guard++;
      @(negedge clk);
    end
    chk(k == (rd ? 4 : 4 + len), "R4 word count", k, rd ? 4 : 4 + len);
    chk(go && !port_we, "R5 go", go, 1);
    chk(go_i2c == !nat, "R5 i2c", go_i2c, !nat);
    chk(go_no_addr == (!nat && na), "R5 no_addr", go_no_addr, !nat && na);
    chk(go_no_stop == (!nat && ns), "R5 no_stop", go_no_stop, !nat && ns);
    @(negedge clk);
    chk(!go, "R5 pulse", go, 0);
    if (poke) begin
      req_valid = 1; req_len = 8'd1; req_read = ~rd;
      #1 chk(req_busy == 1, "R10 busy", req_busy, 1);
      @(negedge clk);
      req_valid = 0;
      chk(!done && !go && !port_we, "R10 ignored", done, 0);
    end
    if (rd) begin
      for (int i = 0; i <= nret; i++) begin
        rx_we = 1; rx_first = (i == 0); rx_byte = (i == 0) ? 8'h00 : rep(i - 1);
        @(negedge clk);
      end
      rx_we = 0; rx_first = 0;
    end
    link_done = 1;
    if (collide) begin
      req_valid = 1; req_len = 8'd0; req_native = 1;
      #1 chk(req_busy == 1, "R10 busy at link_done", req_busy, 1);
    end
    @(negedge clk);
    link_done = 0;
    if (!rd) begin
      chk(done && done_status == 2'd0, "R11 done", done_status, 0);
      chk(done_count == 8'(len), "R11 count", done_count, len);
      if (collide) begin
        chk(req_busy == 1, "R10 busy at done", req_busy, 1);
        @(negedge clk);
        chk(req_busy == 0 && !done, "R10 idle", req_busy, 0);
        @(negedge clk);
        req_valid = 0;
        chk(done && done_status == 2'd1, "R7 after collide", done_status, 1);
      end
      @(negedge clk);
      return;
    end
    chk(port_we && port_word == 10'h300, "R8 rewind word", port_word, 10'h300);
    @(negedge clk);
    chk(!rd_valid && !done, "R8 discard", rd_valid, 0);
    @(negedge clk);
    n = (nret < len) ? nret : len;
    got = 0; guard = 0;
    while (!done && guard < 300) begin
      if (rd_valid) begin
        chk(rd_idx == 8'(got) && rd_byte == rep(got), "R8 data", rd_byte, rep(got));
        got++;
      end
      guard++;
      @(negedge clk);
    end
    chk(done && done_status == 2'd0, "R9 status", done_status, 0);
    chk(done_count == 8'(n), "R9 count", done_count, n);
    chk(got == n, "R9 delivered", got, n);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd7031));
    repeat (3) @(negedge clk);
    chk(!done && !go && !port_we && !rd_valid && !req_busy, "R1 reset", done, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!done && !go && !port_we && !rd_valid && !req_busy, "R1 idle", port_we, 0);
    // directed corners
    run_txn(0, 1, 0, 0, 20'hA5C3E, 16, 0, 0, 0);
    run_txn(1, 1, 0, 0, 20'h00100, 17, 0, 0, 0);
    run_txn(0, 0, 1, 1, 20'hFFFFF, 124, 0, 0, 0);
    run_txn(0, 0, 1, 1, 20'h00050, 125, 0, 0, 0);
    run_txn(1, 0, 1, 0, 20'h00050, 128, 128, 0, 0);
    run_txn(1, 0, 0, 0, 20'h00050, 129, 0, 0, 0);
    run_txn(1, 0, 0, 0, 20'h00030, 0, 0, 0, 0);
    run_txn(1, 1, 0, 0, 20'h12345, 8, 0, 0, 0);
    run_txn(1, 1, 0, 0, 20'h12345, 8, 3, 1, 0);
    run_txn(1, 0, 1, 1, 20'h6789A, 10, 12, 0, 0);
    run_txn(0, 0, 0, 1, 20'h00222, 2, 0, 0, 1);
    // random mix
    for (int t = 0; t < 40; t++) begin
      bit rd, nat;
      int len, nret;
      rd   = 1'($urandom);
      nat  = 1'($urandom);
      len  = ($urandom % 8 == 0) ? int'($urandom % 140) : int'($urandom % (nat ? 18 : 40));
      nret = int'($urandom % (len + 3));
      run_txn(rd, nat, 1'($urandom), 1'($urandom), 20'($urandom), len, nret,
              ($urandom % 5 == 0), 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule